// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This unit sits next to the ECC checker of a DRAM controller. Each cycle the checker may report a correctable (single-bit) or uncorrectable (multi-bit) event, together with the access address, the 64-bit data word and the check bits it saw. The unit keeps sticky flags for both error kinds. It holds one snapshot of the access that first raised a flag, and it raises a level interrupt while an enabled flag is pending.

Correctable events do not raise their flag at once. They advance a counter, and the flag is set only when the count reaches a programmable threshold. A threshold of zero turns correctable reporting off. Software programs and inspects the unit through a plain 32-bit register port with a word address and a write strobe. Reads are combinational from the register state. Flags are cleared by writing ones to them.

Top module: `mem_err_logger`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: An unmasked uncorrectable event sets status bit 1 at the next clock edge.
- R3: Each unmasked correctable event with a nonzero threshold adds one to the counter. The event that brings the count up to the threshold sets status bit 1'b0 position (bit 0) and returns the counter to zero. The threshold control word (offset 3) reads the threshold in bits 23:16 and the current count in bits 7:0.
- R4: With a threshold of zero, correctable events change neither the counter nor status bit 0.
- R5: Mask register bit 0 (correctable) and bit 1 (uncorrectable) make the matching events invisible: no count, no flag, no snapshot.
- R6: A write to status (offset 0) clears exactly the bits written as one. A flag being set in the same cycle wins over the clear.
- R7: The snapshot loads only when status was zero and a flag is being set in that cycle. It then holds unchanged while any flag stays pending.
- R8: The captured check bits keep their low 8 bits when config bit 0 is 0 (64-bit bus) and their low 16 bits when it is 1 (32-bit bus). All higher bits read as zero.
- R9: `irq` is high exactly while some status bit and the matching enable bit (offset 1: bit 0 correctable, bit 1 uncorrectable) are both set.
- R10: Writing the threshold control word loads bits 23:16 as the threshold and resets the count to zero. A correctable event in that same cycle is not counted.
- R11: Word map: 0 status, 1 interrupt enable, 2 mask, 3 threshold control, 4 config, 5 data high word, 6 data low word, 7 check bits, 8 address low word, 9 address high word. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_sbe | input | 1 | Correctable error seen on this access |
| ev_mbe | input | 1 | Uncorrectable error seen on this access |
| ev_addr | input | 64 | Address of the access |
| ev_data | input | 64 | Data word as read |
| ev_chk | input | CHK_W | Check bits or syndrome of the access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a status clear landing in the very cycle that a new error sets a flag. The bench builds it by driving the clearing write and an uncorrectable event on the same falling edge, and it checks that the flag survives. A second hard case is the threshold edge: the bench steps correctable events one at a time, reads the live count after each, and expects the flag only on the event that makes the count equal the threshold. It also confirms that a threshold rewrite in mid-count restarts the window from zero.

// File: rtl/mel_pkg.sv
`timescale 1ns/1ps
package mel_pkg;
    localparam int REG_W        = 32;
    localparam int WORD64_W     = 2 * REG_W;
    localparam int THR_LSB      = 16;
    localparam int WIDE_SYN_W   = 8;
    localparam int NARROW_SYN_W = 16;

    localparam int FLAG_SB = 0;
    localparam int FLAG_MB = 1;
    localparam int FLAG_W  = 2;

    localparam int OFF_STATUS  = 0;
    localparam int OFF_IRQ_EN  = 1;
    localparam int OFF_MASK    = 2;
    localparam int OFF_THRESH  = 3;
    localparam int OFF_CFG     = 4;
    localparam int OFF_CAP_DHI = 5;
    localparam int OFF_CAP_DLO = 6;
    localparam int OFF_CAP_CHK = 7;
    localparam int OFF_CAP_ALO = 8;
    localparam int OFF_CAP_AHI = 9;
endpackage

// File: rtl/mel_sbe_counter.sv
`timescale 1ns/1ps
module mel_sbe_counter #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    output logic [THR_W-1:0] thr_o,
    output logic [THR_W-1:0] cnt_o,
    output logic             fire_o
);
    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic [THR_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [THR_W:0]   cnt_next;

    always_comb begin
        st_d     = st_q;
        fire_o   = 1'b0;
        cnt_next = {1'b0, st_q.cnt} + {{THR_W{1'b0}}, 1'b1};
        if (thr_we) begin
            st_d.thr = thr_wdata;
            st_d.cnt = '0;
        end else if (hit && (st_q.thr != '0)) begin
            if (cnt_next >= {1'b0, st_q.thr}) begin
                fire_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_next[THR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign thr_o = st_q.thr;
    assign cnt_o = st_q.cnt;

    // R3: the count never sits at or above a nonzero threshold
    assert_cnt_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt < st_q.thr) || (st_q.cnt == '0));

    // R4: a zero threshold leaves the count untouched
    assert_zero_thr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.thr == '0 && !thr_we) |=> $stable(st_q.cnt));

    // R10: a threshold write restarts the window
    assert_thr_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        thr_we |=> (st_q.cnt == '0));
endmodule

// File: rtl/mel_snapshot.sv
`timescale 1ns/1ps
module mel_snapshot
    import mel_pkg::*;
#(
    parameter int CHK_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                narrow,
    input  logic [WORD64_W-1:0] ev_addr,
    input  logic [WORD64_W-1:0] ev_data,
    input  logic [CHK_W-1:0]    ev_chk,
    output logic [WORD64_W-1:0] cap_addr,
    output logic [WORD64_W-1:0] cap_data,
    output logic [CHK_W-1:0]    cap_chk
);
    function automatic logic [CHK_W-1:0] keep_low(input int n);
        logic [CHK_W-1:0] m;
        for (int i = 0; i < CHK_W; i++) m[i] = (i < n);
        return m;
    endfunction

    localparam logic [CHK_W-1:0] WIDE_KEEP   = keep_low(WIDE_SYN_W);
    localparam logic [CHK_W-1:0] NARROW_KEEP = keep_low(NARROW_SYN_W);

    typedef struct packed {
        logic [WORD64_W-1:0] addr;
        logic [WORD64_W-1:0] data;
        logic [CHK_W-1:0]    chk;
    } snap_t;

    snap_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (load) begin
            snap_d.addr = ev_addr;
            snap_d.data = ev_data;
            snap_d.chk  = ev_chk & (narrow ? NARROW_KEEP : WIDE_KEEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign cap_addr = snap_q.addr;
    assign cap_data = snap_q.data;
    assign cap_chk  = snap_q.chk;

    // R7: without a load the snapshot does not move
    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(snap_q));
endmodule

// File: rtl/mem_err_logger.sv
`timescale 1ns/1ps
module mem_err_logger
    import mel_pkg::*;
#(
    parameter int CHK_W  = 16,
    parameter int THR_W  = 8,
    parameter int REG_AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_sbe,
    input  logic                ev_mbe,
    input  logic [WORD64_W-1:0] ev_addr,
    input  logic [WORD64_W-1:0] ev_data,
    input  logic [CHK_W-1:0]    ev_chk,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                irq
);
    typedef struct packed {
        logic [FLAG_W-1:0] status;
        logic [FLAG_W-1:0] irq_en;
        logic [FLAG_W-1:0] mask;
        logic              narrow;
    } ctl_state_t;

    ctl_state_t           ctl_d, ctl_q;
    logic                 sb_hit, mb_hit, sb_fire;
    logic [FLAG_W-1:0]    set_v, clr_v;
    logic                 snap_load;
    logic                 thr_we;
    logic [THR_W-1:0]     thr_q, cnt_q;
    logic [WORD64_W-1:0]  cap_addr, cap_data;
    logic [CHK_W-1:0]     cap_chk;

    function automatic logic wr_at(input int off);
        return reg_wr && (reg_addr == REG_AW'(off));
    endfunction

    always_comb begin
        ctl_d     = ctl_q;
        sb_hit    = ev_sbe && !ctl_q.mask[FLAG_SB];
        mb_hit    = ev_mbe && !ctl_q.mask[FLAG_MB];
        set_v     = '0;
        set_v[FLAG_SB] = sb_fire;
        set_v[FLAG_MB] = mb_hit;
        clr_v     = wr_at(OFF_STATUS) ? reg_wdata[FLAG_W-1:0] : '0;
        thr_we    = wr_at(OFF_THRESH);
        snap_load = (ctl_q.status == '0) && (set_v != '0);

        ctl_d.status = (ctl_q.status & ~clr_v) | set_v;
        if (wr_at(OFF_IRQ_EN)) ctl_d.irq_en = reg_wdata[FLAG_W-1:0];
        if (wr_at(OFF_MASK))   ctl_d.mask   = reg_wdata[FLAG_W-1:0];
        if (wr_at(OFF_CFG))    ctl_d.narrow = reg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    mel_sbe_counter #(.THR_W(THR_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (sb_hit),
        .thr_we    (thr_we),
        .thr_wdata (reg_wdata[THR_LSB +: THR_W]),
        .thr_o     (thr_q),
        .cnt_o     (cnt_q),
        .fire_o    (sb_fire)
    );

    mel_snapshot #(.CHK_W(CHK_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (snap_load),
        .narrow   (ctl_q.narrow),
        .ev_addr  (ev_addr),
        .ev_data  (ev_data),
        .ev_chk   (ev_chk),
        .cap_addr (cap_addr),
        .cap_data (cap_data),
        .cap_chk  (cap_chk)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(OFF_STATUS):  reg_rdata = REG_W'(ctl_q.status);
            REG_AW'(OFF_IRQ_EN):  reg_rdata = REG_W'(ctl_q.irq_en);
            REG_AW'(OFF_MASK):    reg_rdata = REG_W'(ctl_q.mask);
            REG_AW'(OFF_THRESH): begin
                reg_rdata[THR_LSB +: THR_W] = thr_q;
                reg_rdata[0 +: THR_W]       = cnt_q;
            end
            REG_AW'(OFF_CFG):     reg_rdata = REG_W'(ctl_q.narrow);
            REG_AW'(OFF_CAP_DHI): reg_rdata = cap_data[REG_W +: REG_W];
            REG_AW'(OFF_CAP_DLO): reg_rdata = cap_data[0 +: REG_W];
            REG_AW'(OFF_CAP_CHK): reg_rdata = REG_W'(cap_chk);
            REG_AW'(OFF_CAP_ALO): reg_rdata = cap_addr[0 +: REG_W];
            REG_AW'(OFF_CAP_AHI): reg_rdata = cap_addr[REG_W +: REG_W];
            default:              reg_rdata = '0;
        endcase
    end

    assign irq = |(ctl_q.status & ctl_q.irq_en);

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    // R2: an unmasked uncorrectable event is flagged on the next edge
    assert_mb_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mbe && !ctl_q.mask[FLAG_MB]) |=> ctl_q.status[FLAG_MB]);

    // R6: a pending flag stays until a one is written to it
    assert_sb_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.status[FLAG_SB] && !(wr_at(OFF_STATUS) && reg_wdata[FLAG_SB]))
        |=> ctl_q.status[FLAG_SB]);

    // R7: the first snapshot survives while anything is pending
    assert_first_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.status != '0) |=> ($stable(cap_addr) && $stable(cap_data) && $stable(cap_chk)));

    // R9: the interrupt only drops after a register write
    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr) |=> irq);
endmodule

// File: tb/mem_err_logger_bench.sv
`timescale 1ns/1ps
module mem_err_logger_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ev_sbe, ev_mbe;
    logic [63:0] ev_addr, ev_data;
    logic [15:0] ev_chk;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mem_err_logger u_mem_err_logger (
        .clk(clk), .rst_n(rst_n), .ev_sbe(ev_sbe), .ev_mbe(ev_mbe),
        .ev_addr(ev_addr), .ev_data(ev_data), .ev_chk(ev_chk),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input string tag, input int a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic irq_is(input string tag, input bit exp);
        @(negedge clk);
        #1;
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic fire(input bit s, input bit m, input logic [63:0] a,
                        input logic [63:0] d, input logic [15:0] c);
        @(negedge clk);
        ev_sbe = s; ev_mbe = m; ev_addr = a; ev_data = d; ev_chk = c;
        @(negedge clk);
        ev_sbe = 1'b0; ev_mbe = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 10; a++) rd("R1 reset reg", a, 32'h0);
        rd("R11 unmapped offset", 12, 32'h0);
        irq_is("R1 irq after reset", 1'b0);
    endtask

    task automatic t_multi();
        wr(1, 32'h2);
        fire(1'b0, 1'b1, 64'h0000_0012_3456_7890, 64'hDEAD_BEEF_0BAD_F00D, 16'hABCD);
        rd("R2 mb flag", 0, 32'h2);
        irq_is("R9 irq on enabled mb", 1'b1);
        rd("R7 cap addr lo", 8, 32'h3456_7890);
        rd("R7 cap addr hi", 9, 32'h0000_0012);
        rd("R7 cap data hi", 5, 32'hDEAD_BEEF);
        rd("R7 cap data lo", 6, 32'h0BAD_F00D);
        rd("R8 wide chk keeps 8", 7, 32'h0000_00CD);
        fire(1'b0, 1'b1, 64'h1111_1111_2222_2222, 64'h5, 16'h0077);
        rd("R7 first addr kept", 8, 32'h3456_7890);
        rd("R7 first data kept", 6, 32'h0BAD_F00D);
        wr(0, 32'h1);
        rd("R6 other bit untouched", 0, 32'h2);
        wr(0, 32'h2);
        rd("R6 w1c clears", 0, 32'h0);
        irq_is("R9 irq drops", 1'b0);
    endtask

    task automatic t_threshold();
        wr(3, 32'h0003_0000);
        rd("R3 thr readback", 3, 32'h0003_0000);
        fire(1'b1, 1'b0, 64'hA1, 64'hB1, 16'h01);
        rd("R3 count 1", 3, 32'h0003_0001);
        fire(1'b1, 1'b0, 64'hA2, 64'hB2, 16'h02);
        rd("R3 count 2 no flag", 0, 32'h0);
        rd("R3 count 2", 3, 32'h0003_0002);
        fire(1'b1, 1'b0, 64'hA3, 64'hB3, 16'h03);
        rd("R3 flag at thr", 0, 32'h1);
        rd("R3 count wraps", 3, 32'h0003_0000);
        rd("R7 capture is firing event", 8, 32'h0000_00A3);
        irq_is("R9 sb not enabled", 1'b0);
        wr(1, 32'h1);
        irq_is("R9 sb enabled", 1'b1);
        wr(0, 32'hFFFF_FFFF);
        rd("R6 all ones clear", 0, 32'h0);
        fire(1'b1, 1'b0, 64'hA4, 64'hB4, 16'h04);
        fire(1'b1, 1'b0, 64'hA5, 64'hB5, 16'h05);
        rd("R3 counting again", 3, 32'h0003_0002);
        wr(3, 32'h0003_0000);
        rd("R10 rewrite clears count", 3, 32'h0003_0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 32'h0002_0000; ev_sbe = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_sbe = 1'b0;
        rd("R10 same-cycle event dropped", 3, 32'h0002_0000);
        wr(3, 32'h0001_0000);
        fire(1'b1, 1'b0, 64'hA6, 64'hB6, 16'h06);
        rd("R3 threshold one flags each", 0, 32'h1);
        wr(0, 32'h1);
    endtask

    task automatic t_zero_thr();
        wr(3, 32'h0);
        for (int i = 0; i < 3; i++) fire(1'b1, 1'b0, 64'hC0, 64'hC1, 16'h0);
        rd("R4 no flag at thr 0", 0, 32'h0);
        rd("R4 no count at thr 0", 3, 32'h0);
    endtask

    task automatic t_mask();
        wr(3, 32'h0001_0000);
        wr(2, 32'h3);
        fire(1'b1, 1'b1, 64'hEE, 64'hEF, 16'hFF);
        rd("R5 masked no flag", 0, 32'h0);
        rd("R5 masked no count", 3, 32'h0001_0000);
        rd("R5 masked no capture", 8, 32'h0000_00A6);
        wr(2, 32'h1);
        fire(1'b1, 1'b1, 64'hF0, 64'hF1, 16'h0);
        rd("R5 only sb masked", 0, 32'h2);
        wr(0, 32'h3);
        wr(2, 32'h0);
        fire(1'b1, 1'b1, 64'hF2, 64'hF3, 16'h0);
        rd("R3 R2 both flags", 0, 32'h3);
        wr(0, 32'h3);
    endtask

    task automatic t_narrow();
        wr(4, 32'h1);
        rd("R11 cfg readback", 4, 32'h1);
        fire(1'b0, 1'b1, 64'h10, 64'h20, 16'hABCD);
        rd("R8 narrow chk keeps 16", 7, 32'h0000_ABCD);
        wr(0, 32'h2);
        wr(4, 32'h0);
    endtask

    task automatic t_race();
        fire(1'b0, 1'b1, 64'h30, 64'h40, 16'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h3; ev_mbe = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_mbe = 1'b0;
        rd("R6 set beats clear", 0, 32'h2);
        wr(0, 32'h2);
        rd("R6 cleared after race", 0, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; ev_sbe = 1'b0; ev_mbe = 1'b0; ev_addr = '0; ev_data = '0;
        ev_chk = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_multi();
        t_threshold();
        t_zero_thr();
        t_mask();
        t_narrow();
        t_race();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule